// File: doc/BRIEF.md
# Multiplexed Local Bus Cycle Controller

This block produces the external timing for one transfer on an 8-bit-data, 20-bit-address processor bus. The address and data share the low byte lines. The core presents a transfer: read or write, memory or I/O, an address, write data, and a two-bit tag for the segment class in use. The controller then steps through the address state T1, the strobe states T2 and T3, any wait states Tw, and the closing state T4. In T1 it places the address on the shared lines and pulses a latch strobe. In the later states the same lines carry data, and the top four lines carry status instead of address.

An external agent can take the bus with a hold request. The controller gives up the bus only between transfers. While the hold is granted, every bus output has its enable deasserted. High impedance is shown by separate output-enable signals, and the pad ring builds the actual tristate drivers. The core sees `busy` while a transfer runs. It sees a one-clock `done` pulse in T4, and for reads `rdata` holds the captured byte at that point.

Top module: `lbus_cycle_ctrl`

## Requirements
- R1: A transfer is accepted only in the idle state when `hold_req` is low. The clock after acceptance is T1. In T1, `ale` is 1 for exactly that clock, `ad_oe` is 1, and `ad_out` carries address bits 7:0.
- R2: `addr_mid` carries address bits 15:8 of the current transfer in every state from T1 through T4.
- R3: In T1, `as_out[3:0]` carries address bits 19:16 for a memory transfer (`req_io`=0) and 0000 for an I/O transfer (`req_io`=1).
- R4: In T2, T3, Tw and T4, `as_out` is the status nibble. Bit 3 is 0 and bit 2 is the interrupt-enable flag. Bits 1:0 are the segment tag: 00 alternate data, 01 stack, 10 code or none, 11 data.
- R5: Status bit 2 is a register that loads `int_en` on every clock. A change of `int_en` appears on `as_out[2]` one clock later, even in the middle of a transfer.
- R6: In a read, `rd_n` is 0 during T2, T3 and Tw and 1 in every other state. `ad_oe` is 0 from T2 through T4, so the read strobe is never active while the shared lines are driven.
- R7: In a write, `wr_n` is 0 during T2, T3 and Tw and 1 otherwise. `ad_oe` is 1 and `ad_out` carries the write data from T2 through T4. `rd_n` and `wr_n` are never 0 together.
- R8: `ready` is sampled at the clock edge that ends T3 and at the edge that ends each Tw. A low sample adds one Tw; a high sample moves to T4. With `ready` held high, a transfer lasts exactly four clocks.
- R9: A `hold_req` is granted only from the idle state or at the end of T4. It is never granted in T1, T2, T3 or Tw. When both `hold_req` and `req_valid` are present in the idle state, the hold is granted first.
- R10: While `hold_ack` is 1, `bus_oe` and `ad_oe` are 0. One clock after `hold_req` is sampled low, `hold_ack` returns to 0 and `bus_oe` returns to 1.
- R11: `busy` is 1 in T1 through T4. `done` is 1 for exactly one clock, in T4. For a read, `rdata` in T4 equals the `ad_in` value sampled at the edge where `ready` was seen high.
- R12: After reset the controller is idle: `busy`=0, `done`=0, `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `bus_oe`=1, `hold_ack`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core requests a transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_seg | input | 2 | Segment class tag for the status bits |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 8 | Write data |
| int_en | input | 1 | Interrupt-enable flag shown in the status bits |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse in T4 |
| rdata | output | 8 | Captured read data |
| ready | input | 1 | Active-high acknowledge from the addressed device |
| hold_req | input | 1 | External bus hold request |
| hold_ack | output | 1 | Hold granted; bus released |
| ad_in | input | 8 | Shared low lines, receive side |
| ad_out | output | 8 | Shared low lines, drive side |
| ad_oe | output | 1 | Drive enable for the shared low lines |
| addr_mid | output | 8 | Address bits 15:8 |
| as_out | output | 4 | Address bits 19:16 in T1, status afterwards |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| bus_oe | output | 1 | Drive enable for addr_mid, as_out and the strobes |

## Verification
The hold arbitration is the function that can coincide with the core transfer sequencing. The bench raises `hold_req` in the same idle clock as `req_valid` and expects the hold to win and `busy` to stay low. It then raises the hold in T2 of a running transfer and expects the grant only on the clock after T4. A second overlap is a change of `int_en` in the middle of a wait-stretched read. The bench expects the status bit to follow one clock later, while the strobe and wait-state sequence stay undisturbed.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

    localparam int ADDR_W  = 20;
    localparam int DATA_W  = 8;
    localparam int LOW_W   = DATA_W;
    localparam int MID_W   = 8;
    localparam int NIB_W   = ADDR_W - LOW_W - MID_W;
    localparam int NIB_LSB = LOW_W + MID_W;
    localparam int SEG_W   = 2;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5,
        ST_HOLD = 3'd6
    } bus_state_e;

    typedef enum logic [SEG_W-1:0] {
        SEG_ALT   = 2'b00,
        SEG_STACK = 2'b01,
        SEG_CODE  = 2'b10,
        SEG_DATA  = 2'b11
    } seg_e;

    typedef struct packed {
        logic              write;
        logic              io;
        seg_e              seg;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // States in which a strobe may be active
    function automatic logic strobe_phase(bus_state_e s);
        return (s == ST_T2) || (s == ST_T3) || (s == ST_TW);
    endfunction

    // States after the address phase of a transfer
    function automatic logic data_phase(bus_state_e s);
        return strobe_phase(s) || (s == ST_T4);
    endfunction

    // States that belong to a transfer in flight
    function automatic logic in_transfer(bus_state_e s);
        return (s == ST_T1) || data_phase(s);
    endfunction

    // Status nibble: top bit fixed low, then interrupt flag, then segment
    function automatic logic [NIB_W-1:0] status_nibble(logic ie, seg_e seg);
        logic [NIB_W-1:0] n;
        n = '0;
        n[SEG_W-1:0] = seg;
        n[SEG_W]     = ie;
        return n;
    endfunction

endpackage

// File: rtl/lbus_seq.sv
module lbus_seq
    import lbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  bus_req_t   req_in,
    input  logic       ready,
    input  logic       hold_req,
    output bus_state_e state,
    output bus_req_t   cur,
    output logic       capture
);

    bus_state_e state_nx;
    logic       accept;

    assign accept = (state == ST_IDLE) && !hold_req && req_valid;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (hold_req)       state_nx = ST_HOLD;
                else if (req_valid) state_nx = ST_T1;
            end
            ST_T1:   state_nx = ST_T2;
            ST_T2:   state_nx = ST_T3;
            ST_T3,
            ST_TW:   state_nx = ready ? ST_T4 : ST_TW;
            ST_T4:   state_nx = hold_req ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_nx = hold_req ? ST_HOLD : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Read data is taken at the edge that leaves T3 or Tw toward T4
    assign capture = ((state == ST_T3) || (state == ST_TW)) && ready && !cur.write;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cur   <= '0;
        end else begin
            state <= state_nx;
            if (accept) cur <= req_in;
        end
    end

endmodule

// File: rtl/lbus_rdcap.sv
module lbus_rdcap
    import lbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] ad_in,
    input  logic              int_en,
    output logic [DATA_W-1:0] rdata,
    output logic              ie_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            ie_q  <= 1'b0;
        end else begin
            ie_q <= int_en;
            if (capture) rdata <= ad_in;
        end
    end

endmodule

// File: rtl/lbus_pinmux.sv
module lbus_pinmux
    import lbus_pkg::*;
(
    input  bus_state_e        state,
    input  bus_req_t          cur,
    input  logic              ie_q,
    output logic [LOW_W-1:0]  ad_out,
    output logic              ad_oe,
    output logic [MID_W-1:0]  addr_mid,
    output logic [NIB_W-1:0]  as_out,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              bus_oe,
    output logic              busy,
    output logic              done,
    output logic              hold_ack
);

    logic             addr_phase;
    logic [NIB_W-1:0] status;

    assign addr_phase = (state == ST_T1);
    assign status     = status_nibble(ie_q, cur.seg);

    assign ad_out   = addr_phase ? cur.addr[LOW_W-1:0] : cur.wdata;
    assign ad_oe    = addr_phase || (cur.write && data_phase(state));
    assign addr_mid = cur.addr[LOW_W +: MID_W];
    assign ale      = addr_phase;
    assign rd_n     = !(!cur.write && strobe_phase(state));
    assign wr_n     = !( cur.write && strobe_phase(state));
    assign bus_oe   = (state != ST_HOLD);
    assign busy     = in_transfer(state);
    assign done     = (state == ST_T4);
    assign hold_ack = (state == ST_HOLD);

    // Upper lines: address (or zero for I/O) in T1, status afterwards
    for (genvar i = 0; i < NIB_W; i++) begin : g_nib
        assign as_out[i] = addr_phase ? (!cur.io && cur.addr[NIB_LSB + i]) : status[i];
    end

endmodule

// File: rtl/lbus_cycle_ctrl.sv
module lbus_cycle_ctrl
    import lbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              int_en,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    input  logic              ready,
    input  logic              hold_req,
    output logic              hold_ack,
    input  logic [DATA_W-1:0] ad_in,
    output logic [LOW_W-1:0]  ad_out,
    output logic              ad_oe,
    output logic [MID_W-1:0]  addr_mid,
    output logic [NIB_W-1:0]  as_out,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              bus_oe
);

    bus_req_t   req_in;
    bus_req_t   cur;
    bus_state_e state;
    logic       capture;
    logic       ie_q;

    assign req_in = '{write: req_write, io: req_io, seg: seg_e'(req_seg),
                      addr: req_addr, wdata: req_wdata};

    lbus_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_in),
        .ready     (ready),
        .hold_req  (hold_req),
        .state     (state),
        .cur       (cur),
        .capture   (capture)
    );

    lbus_rdcap u_rdcap (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .ad_in   (ad_in),
        .int_en  (int_en),
        .rdata   (rdata),
        .ie_q    (ie_q)
    );

    lbus_pinmux u_pinmux (
        .state    (state),
        .cur      (cur),
        .ie_q     (ie_q),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .addr_mid (addr_mid),
        .as_out   (as_out),
        .ale      (ale),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .bus_oe   (bus_oe),
        .busy     (busy),
        .done     (done),
        .hold_ack (hold_ack)
    );

endmodule

// File: rtl/lbus_cycle_ctrl_chk.sv
module lbus_cycle_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic ad_oe,
    input logic bus_oe,
    input logic hold_ack,
    input logic hold_req,
    input logic busy,
    input logic done,
    input logic ready
);

    // R1: latch strobe lasts one clock
    a_r1_ale_single: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    // R11: latch strobe only inside a transfer
    a_r11_ale_busy: assert property (@(posedge clk) disable iff (rst)
        ale |-> busy);

    // R6: read strobe never while the shared lines are driven
    a_r6_rd_released: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);

    // R7: strobes mutually exclusive
    a_r7_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    // R8: completion follows a high ready sample
    a_r8_done_after_ready: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(ready));

    // R11: completion pulse is one clock
    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: grant only from idle or after T4
    a_r9_grant_boundary: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_ack) |-> $past(!busy || done));

    // R10: released outputs during hold
    a_r10_hold_float: assert property (@(posedge clk) disable iff (rst)
        hold_ack |-> (!bus_oe && !ad_oe));

    // R10: bus returns one clock after the request drops
    a_r10_resume: assert property (@(posedge clk) disable iff (rst)
        (hold_ack && !hold_req) |=> (!hold_ack && bus_oe));

endmodule

bind lbus_cycle_ctrl lbus_cycle_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ale      (ale),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .ad_oe    (ad_oe),
    .bus_oe   (bus_oe),
    .hold_ack (hold_ack),
    .hold_req (hold_req),
    .busy     (busy),
    .done     (done),
    .ready    (ready)
);

// File: tb/lbus_cycle_ctrl_tb_top.sv
module lbus_cycle_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic [1:0]  req_seg = 2'b00;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        int_en = 1'b0;
    logic        ready = 1'b1;
    logic        hold_req = 1'b0;
    logic [7:0]  ad_in = '0;
    logic        busy, done, hold_ack, ad_oe, ale, rd_n, wr_n, bus_oe;
    logic [7:0]  rdata, ad_out, addr_mid;
    logic [3:0]  as_out;

    int checks = 0;
    int fails  = 0;
    logic last_ie = 1'b0;

    always #2.5 clk = ~clk;

    lbus_cycle_ctrl dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_io(req_io), .req_seg(req_seg), .req_addr(req_addr),
        .req_wdata(req_wdata), .int_en(int_en), .busy(busy), .done(done),
        .rdata(rdata), .ready(ready), .hold_req(hold_req), .hold_ack(hold_ack),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .addr_mid(addr_mid),
        .as_out(as_out), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .bus_oe(bus_oe)
    );

    // fields: write, io, seg, waits, ie, addr, data
    localparam int NV = 6;
    localparam logic [34:0] VECS [NV] = '{
        {1'b0, 1'b0, 2'd3, 2'd0, 1'b1, 20'hA5C31, 8'h5A},
        {1'b1, 1'b0, 2'd1, 2'd0, 1'b0, 20'h3F00E, 8'hC3},
        {1'b0, 1'b1, 2'd2, 2'd1, 1'b0, 20'hF1234, 8'h96},
        {1'b1, 1'b1, 2'd0, 2'd2, 1'b1, 20'h7BEEF, 8'h01},
        {1'b0, 1'b0, 2'd0, 2'd3, 1'b0, 20'h80FF0, 8'hFF},
        {1'b1, 1'b0, 2'd2, 2'd1, 1'b1, 20'h0000F, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic strobes(input logic wr, input logic active, input logic [7:0] data);
        check("R6 rd_n", rd_n, !(active && !wr));
        check("R7 wr_n", wr_n, !(active && wr));
        check("R6 R7 ad_oe", ad_oe, wr);
        if (wr) check("R7 write data", ad_out, data);
    endtask

    task automatic run_xfer(input logic wr, input logic io, input logic [1:0] seg,
                            input int waits, input logic ie, input logic [19:0] addr,
                            input logic [7:0] data, input logic flip_ie, input logic hold_mid);
        logic [3:0] exp_nib;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_io = io; req_seg = seg;
        req_addr = addr; req_wdata = data; int_en = ie; ad_in = data; ready = 1'b1;
        last_ie = ie;
        // T1
        @(negedge clk);
        req_valid = 1'b0;
        exp_nib = io ? 4'h0 : addr[19:16];
        check("R1 ale", ale, 1'b1);
        check("R1 ad_oe", ad_oe, 1'b1);
        check("R1 low address", ad_out, addr[7:0]);
        check("R2 mid address T1", addr_mid, addr[15:8]);
        check("R3 upper address", as_out, exp_nib);
        check("R11 busy", busy, 1'b1);
        // T2
        @(negedge clk);
        if (hold_mid) hold_req = 1'b1;
        check("R1 ale low", ale, 1'b0);
        check("R4 status T2", as_out, {1'b0, last_ie, seg});
        strobes(wr, 1'b1, data);
        // T3
        @(negedge clk);
        check("R4 status T3", as_out, {1'b0, last_ie, seg});
        check("R9 no grant in T3", hold_ack, 1'b0);
        strobes(wr, 1'b1, data);
        ready = (waits == 0);
        if (flip_ie) int_en = ~int_en;
        last_ie = int_en;
        for (int w = 0; w < waits; w++) begin
            @(negedge clk);
            check("R8 wait state", done, 1'b0);
            check("R5 R4 status Tw", as_out, {1'b0, last_ie, seg});
            check("R2 mid address Tw", addr_mid, addr[15:8]);
            strobes(wr, 1'b1, data);
            if (w == waits - 1) ready = 1'b1;
        end
        // T4
        @(negedge clk);
        check("R11 done", done, 1'b1);
        check("R4 status T4", as_out, {1'b0, last_ie, seg});
        check("R2 mid address T4", addr_mid, addr[15:8]);
        check("R9 no grant in T4", hold_ack, 1'b0);
        strobes(wr, 1'b0, data);
        if (!wr) check("R11 read data", rdata, data);
        ad_in = ~data;
        @(negedge clk);
        check("R11 done single", done, 1'b0);
        if (hold_mid) begin
            check("R9 grant after T4", hold_ack, 1'b1);
            check("R10 bus released", {bus_oe, ad_oe}, 2'b00);
        end else begin
            check("R11 idle after T4", busy, 1'b0);
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check("R12 busy", busy, 1'b0);
        check("R12 done", done, 1'b0);
        check("R12 ale", ale, 1'b0);
        check("R12 strobes", {rd_n, wr_n}, 2'b11);
        check("R12 enables", {ad_oe, bus_oe, hold_ack}, 3'b010);

        // Table walk (R1-related timing, R8 nominal length covered by waits=0)
        for (int i = 0; i < NV; i++) begin
            logic [34:0] v;
            v = VECS[i];
            run_xfer(v[34], v[33], v[32:31], int'(v[30:29]), v[28], v[27:8], v[7:0], 1'b0, 1'b0);
        end

        // R5: flag change mid-transfer shows one clock later
        run_xfer(1'b0, 1'b0, 2'd1, 2, 1'b0, 20'h45678, 8'h3C, 1'b1, 1'b0);

        // R9: hold raised in T2 waits until after T4
        run_xfer(1'b1, 1'b0, 2'd3, 1, 1'b1, 20'h12345, 8'hA7, 1'b0, 1'b1);
        @(negedge clk);
        hold_req = 1'b0;
        @(negedge clk);
        check("R10 resume hold_ack", hold_ack, 1'b0);
        check("R10 resume bus_oe", bus_oe, 1'b1);

        // R9: hold and request together in idle, hold wins
        hold_req = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h55555;
        @(negedge clk);
        check("R9 hold first", hold_ack, 1'b1);
        check("R9 no transfer", busy, 1'b0);
        check("R10 float ad", ad_oe, 1'b0);
        @(negedge clk);
        check("R9 still held", {hold_ack, busy}, 2'b10);
        hold_req = 1'b0;
        @(negedge clk);
        check("R10 back to idle", {hold_ack, bus_oe, busy}, 3'b010);
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 pending request starts", ale, 1'b1);
        check("R1 pending address", ad_out, 8'h55);
        repeat (4) @(negedge clk);
        check("R11 idle again", busy, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule